// File: doc/BRIEF.md
# ADC Channel and Reference Selection Shadow Controller

This block keeps the analog multiplexer selection of a successive-approximation ADC sequencer stable while a conversion is in progress. Software may write a 7-bit selection word, a 5-bit channel number and a 2-bit reference code, at any moment into a visible register. The analog front end only ever sees a shadow copy of that word. The shadow copy follows the visible register while the converter is idle. It is held from the edge on which a conversion begins and is released again on the edge that ends the conversion.

Conversions can be started in three ways. Software can pulse a start bit. In triggered mode, a rising edge on a trigger input starts a conversion. In free-running mode, each completed conversion starts the next one on the same edge, so a selection written during conversion N is first used by conversion N+2. Every conversion lasts a fixed number of ADC clocks. At the end of it, the block sets a sticky completion flag and captures the converter's 10-bit result together with the selection that conversion used. A result that follows a change of reference is marked as one to discard.

Top module: `adc_mux_shadow_ctrl`

## Requirements
- R1: While `rst` is high, `sel_reg`, `mux_chan`, `mux_ref`, `busy`, `done_flag`, `result`, `result_sel` and `result_discard` all go to zero on the next clock edge.
- R2: A clock edge with `sel_we` high loads `sel_wdata` into `sel_reg` in any state, whether idle, converting or disabled. Bits [6:5] are the reference code and bits [4:0] are the channel.
- R3: On every edge where no conversion is running, the shadow copy (`{mux_ref, mux_chan}`) takes the value `sel_reg` had before that edge. A write therefore reaches the mux outputs one clock after it appears in `sel_reg`.
- R4: With `en` high, a `start_wr` pulse sampled on edge E0 raises `busy` on edge E0+1, the start edge. A `start_wr` pulse while `busy` is high, or while `en` is low, has no effect.
- R5: From the start edge until the final cycle of the conversion, the mux outputs do not change, even if `sel_reg` is written.
- R6: A conversion lasts CONV_CYCLES clocks (default 13). On the edge CONV_CYCLES clocks after the start edge, `done_flag` is set and `result` captures `conv_data`. `result_sel` takes the mux value that held before the start edge. The shadow reloads from `sel_reg`, and in single mode `busy` falls.
- R7: In free-running mode (`mode` = 1), the completion edge also starts the next conversion and `busy` stays high. The new conversion uses the shadow value from before that edge, so a selection written during conversion N appears in `result_sel` from conversion N+2. Leaving the mode stops the chain after the current conversion.
- R8: In triggered mode (`mode` = 2), a rising edge of `trig_in` acts like `start_wr`. A rising edge while `busy` is high, or in any other mode, is ignored and is not queued.
- R9: `result_discard` is set with a result whose reference code differs from the reference code of the previous completed result. Reference code 0 is assumed before the first result after reset.
- R10: An edge with `flag_clr` high clears `done_flag`. If a completion happens on the same edge, the flag ends up set.
- R11: Driving `en` low ends any conversion on the next edge without setting `done_flag`. The shadow then follows `sel_reg` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable; low aborts and holds idle |
| mode | input | 2 | 0 single, 1 free-running, 2 triggered |
| sel_we | input | 1 | Write strobe for the visible selection register |
| sel_wdata | input | 7 | Selection write data {ref[1:0], chan[4:0]} |
| start_wr | input | 1 | Software start pulse |
| trig_in | input | 1 | Auto-trigger source, rising-edge sensitive |
| flag_clr | input | 1 | Write-one-to-clear for the completion flag |
| conv_data | input | 10 | Result from the stubbed converter |
| sel_reg | output | 7 | Visible selection register |
| mux_chan | output | 5 | Shadow channel driven to the analog mux |
| mux_ref | output | 2 | Shadow reference code driven to the front end |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky completion flag |
| result | output | 10 | Captured conversion result |
| result_sel | output | 7 | Selection used by the captured result |
| result_discard | output | 1 | Result follows a reference change |

## Verification
The bench builds the block with its default parameters: a 13-clock conversion and the full 5-bit channel and 2-bit reference fields. At these values every reference code and the extreme channel numbers 0 and 31 can be reached. The exact edge counts of the start, the freeze and the completion can be checked against the stated conversion length, and the N+2 delay of free-running mode can be observed across three chained conversions.

// File: rtl/adc_sel_pkg.sv
package adc_sel_pkg;

    localparam int CHAN_W = 5;
    localparam int REF_W  = 2;
    localparam int SEL_W  = CHAN_W + REF_W;

    typedef enum logic [REF_W-1:0] {
        REF_EXT_PIN = 2'd0,
        REF_SUPPLY  = 2'd1,
        REF_INT_LO  = 2'd2,
        REF_INT_HI  = 2'd3
    } ref_e;

    typedef struct packed {
        ref_e              refsel;
        logic [CHAN_W-1:0] chan;
    } sel_t;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_FREE   = 2'd1,
        MODE_TRIG   = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    function automatic sel_t to_sel(input logic [SEL_W-1:0] raw);
        sel_t s;
        s.refsel = ref_e'(raw[SEL_W-1:CHAN_W]);
        s.chan   = raw[CHAN_W-1:0];
        return s;
    endfunction

    function automatic logic [SEL_W-1:0] from_sel(input sel_t s);
        return {s.refsel, s.chan};
    endfunction

endpackage

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_sel_pkg::*;
#(
    parameter int CONV_CYCLES = 13
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  mode_e mode,
    input  logic  start_wr,
    input  logic  trig_in,
    output logic  busy,
    output logic  final_cyc,
    output logic  launch,
    output logic  done
);
    localparam int              CNT_W = $clog2(CONV_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic             trig_q;
    logic             trig_rise;
    logic             req;

    assign trig_rise = trig_in & ~trig_q;
    assign req       = start_wr | ((mode == MODE_TRIG) & trig_rise);
    assign final_cyc = busy && (cnt == LAST);
    assign launch    = en && ((pend && !busy) || (final_cyc && mode == MODE_FREE));
    assign done      = en && final_cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy <= 1'b0;
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (launch) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (final_cyc) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (busy) begin
                cnt  <= cnt + 1'b1;
            end

            if (launch) begin
                pend <= 1'b0;
            end else if (req && !busy) begin
                pend <= 1'b1;
            end
        end
    end

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (en && pend && !busy) |=> busy);                                      // R4
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> (!busy));                                                   // R11
    AST_FREE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (done && mode == MODE_FREE) |=> busy);                                // R7

endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow
    import adc_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             lock,
    output sel_t             sel_vis,
    output sel_t             sel_shd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_vis <= '0;
        end else if (sel_we) begin
            sel_vis <= to_sel(sel_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_shd <= '0;
        end else if (!lock) begin
            sel_shd <= sel_vis;
        end
    end

    AST_WRITE_ANY_STATE: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> (from_sel(sel_vis) == $past(sel_wdata)));                  // R2

endmodule

// File: rtl/adc_result_stage.sv
module adc_result_stage
    import adc_sel_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             done,
    input  sel_t             sel_shd,
    input  logic [RES_W-1:0] conv_data,
    input  logic             flag_clr,
    output logic [RES_W-1:0] result,
    output sel_t             result_sel,
    output logic             result_discard,
    output logic             done_flag
);
    sel_t tag;
    ref_e last_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag <= '0;
        end else if (launch) begin
            tag <= sel_shd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result         <= '0;
            result_sel     <= '0;
            result_discard <= 1'b0;
            last_ref       <= REF_EXT_PIN;
        end else if (done) begin
            result         <= conv_data;
            result_sel     <= tag;
            result_discard <= (tag.refsel != last_ref);
            last_ref       <= tag.refsel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag <= 1'b0;
        end else if (done) begin
            done_flag <= 1'b1;
        end else if (flag_clr) begin
            done_flag <= 1'b0;
        end
    end

    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> done_flag);                                                  // R10
    AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        done |=> (result == $past(conv_data)));                               // R6

endmodule

// File: rtl/adc_mux_shadow_ctrl.sv
module adc_mux_shadow_ctrl
    import adc_sel_pkg::*;
#(
    parameter int CONV_CYCLES = 13,
    parameter int RES_W       = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [1:0]          mode,
    input  logic                sel_we,
    input  logic [SEL_W-1:0]    sel_wdata,
    input  logic                start_wr,
    input  logic                trig_in,
    input  logic                flag_clr,
    input  logic [RES_W-1:0]    conv_data,
    output logic [SEL_W-1:0]    sel_reg,
    output logic [CHAN_W-1:0]   mux_chan,
    output logic [REF_W-1:0]    mux_ref,
    output logic                busy,
    output logic                done_flag,
    output logic [RES_W-1:0]    result,
    output logic [SEL_W-1:0]    result_sel,
    output logic                result_discard
);
    logic  final_cyc;
    logic  launch;
    logic  done;
    logic  lock;
    sel_t  sel_vis;
    sel_t  sel_shd;
    sel_t  res_sel;

    adc_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mode      (mode_e'(mode)),
        .start_wr  (start_wr),
        .trig_in   (trig_in),
        .busy      (busy),
        .final_cyc (final_cyc),
        .launch    (launch),
        .done      (done)
    );

    assign lock = busy && !final_cyc;

    adc_sel_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .lock      (lock),
        .sel_vis   (sel_vis),
        .sel_shd   (sel_shd)
    );

    adc_result_stage #(.RES_W(RES_W)) u_result (
        .clk            (clk),
        .rst            (rst),
        .launch         (launch),
        .done           (done),
        .sel_shd        (sel_shd),
        .conv_data      (conv_data),
        .flag_clr       (flag_clr),
        .result         (result),
        .result_sel     (res_sel),
        .result_discard (result_discard),
        .done_flag      (done_flag)
    );

    assign sel_reg    = from_sel(sel_vis);
    assign mux_chan   = sel_shd.chan;
    assign mux_ref    = sel_shd.refsel;
    assign result_sel = from_sel(res_sel);

    AST_IDLE_TRACK: assert property (@(posedge clk) disable iff (rst)
        (!busy) |=> ({mux_ref, mux_chan} == $past(sel_reg)));                 // R3
    AST_FROZEN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (busy && !final_cyc) |=> $stable({mux_ref, mux_chan}));               // R5

endmodule

// File: tb/test_adc_mux_shadow_ctrl.sv
module test_adc_mux_shadow_ctrl;

    logic       clk = 1'b0;
    logic       rst, en, sel_we, start_wr, trig_in, flag_clr;
    logic [1:0] mode;
    logic [6:0] sel_wdata;
    logic [9:0] conv_data;
    logic [6:0] sel_reg, result_sel;
    logic [4:0] mux_chan;
    logic [1:0] mux_ref;
    logic       busy, done_flag, result_discard;
    logic [9:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    adc_mux_shadow_ctrl i_adc_mux_shadow_ctrl (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .start_wr(start_wr), .trig_in(trig_in),
        .flag_clr(flag_clr), .conv_data(conv_data), .sel_reg(sel_reg),
        .mux_chan(mux_chan), .mux_ref(mux_ref), .busy(busy),
        .done_flag(done_flag), .result(result), .result_sel(result_sel),
        .result_discard(result_discard)
    );

    // {sel[6:0], conv_data[9:0], expected discard}
    localparam logic [17:0] VEC [7] = '{
        {7'h03, 10'h155, 1'b0},
        {7'h1F, 10'h3FF, 1'b0},
        {7'h20, 10'h000, 1'b1},
        {7'h31, 10'h2AA, 1'b0},
        {7'h69, 10'h123, 1'b1},
        {7'h49, 10'h0F0, 1'b1},
        {7'h5E, 10'h3FE, 1'b0}
    };

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_sel(input logic [6:0] v);
        sel_we = 1'b1; sel_wdata = v;
        tick(1);
        sel_we = 1'b0;
    endtask

    task automatic pulse_start();
        start_wr = 1'b1;
        tick(1);
        start_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        summary();
    end

    initial begin
        logic [6:0] prev_sel;
        rst = 1'b1; en = 1'b0; mode = 2'd0; sel_we = 1'b0; sel_wdata = '0;
        start_wr = 1'b0; trig_in = 1'b0; flag_clr = 1'b0; conv_data = '0;
        tick(3);
        check("R1 sel_reg", 32'(sel_reg), 0);
        check("R1 mux", 32'({mux_ref, mux_chan}), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 done_flag", 32'(done_flag), 0);
        check("R1 result", 32'(result), 0);
        check("R1 result_sel", 32'(result_sel), 0);
        check("R1 discard", 32'(result_discard), 0);
        rst = 1'b0; en = 1'b1;
        tick(2);

        // Vector table: single conversions
        prev_sel = 7'h00;
        for (int i = 0; i < 7; i++) begin
            logic [6:0] s;
            logic [9:0] d;
            logic       dis;
            {s, d, dis} = VEC[i];
            pulse_clr();
            check("R10 flag cleared", 32'(done_flag), 0);
            conv_data = d;
            write_sel(s);
            check("R2 sel_reg written", 32'(sel_reg), 32'(s));
            check("R3 mux lags one clock", 32'({mux_ref, mux_chan}), 32'(prev_sel));
            pulse_start();
            check("R3 mux tracks", 32'({mux_ref, mux_chan}), 32'(s));
            check("R4 not busy at request edge", 32'(busy), 0);
            tick(1);
            check("R4 busy on start edge", 32'(busy), 1);
            tick(12);
            check("R6 still busy last cycle", 32'(busy), 1);
            check("R6 no flag early", 32'(done_flag), 0);
            tick(1);
            check("R6 done flag", 32'(done_flag), 1);
            check("R6 busy falls", 32'(busy), 0);
            check("R6 result", 32'(result), 32'(d));
            check("R6 result_sel", 32'(result_sel), 32'(s));
            check("R9 discard", 32'(result_discard), 32'(dis));
            prev_sel = s;
        end

        // R5: write during conversion is held off until completion
        pulse_clr();
        write_sel(7'h44);
        pulse_start();
        tick(1);
        check("R4 busy", 32'(busy), 1);
        tick(3);
        write_sel(7'h47);
        check("R2 write while busy", 32'(sel_reg), 32'h47);
        check("R5 mux frozen", 32'({mux_ref, mux_chan}), 32'h44);
        tick(5);
        check("R5 mux frozen later", 32'({mux_ref, mux_chan}), 32'h44);
        tick(3);
        check("R5 mux frozen last cycle", 32'({mux_ref, mux_chan}), 32'h44);
        tick(1);
        check("R6 done after freeze", 32'(done_flag), 1);
        check("R6 result_sel old", 32'(result_sel), 32'h44);
        check("R6 shadow reloads", 32'({mux_ref, mux_chan}), 32'h47);
        check("R9 same ref no discard", 32'(result_discard), 0);

        // R4: start while busy is ignored
        pulse_clr();
        pulse_start();
        tick(1);
        pulse_start();
        tick(11);
        check("R4 busy before end", 32'(busy), 1);
        tick(1);
        check("R4 done", 32'(done_flag), 1);
        check("R4 busy falls", 32'(busy), 0);
        tick(3);
        check("R4 start while busy ignored", 32'(busy), 0);

        // R7: free-running chain
        pulse_clr();
        mode = 2'd1;
        write_sel(7'h41);
        pulse_start();
        tick(1);
        tick(4);
        write_sel(7'h42);
        tick(7);
        tick(1);
        check("R7 first done", 32'(done_flag), 1);
        check("R7 first result_sel", 32'(result_sel), 32'h41);
        check("R7 stays busy", 32'(busy), 1);
        check("R7 shadow new", 32'({mux_ref, mux_chan}), 32'h42);
        pulse_clr();
        check("R7 flag cleared", 32'(done_flag), 0);
        tick(11);
        check("R7 second not done", 32'(done_flag), 0);
        tick(1);
        check("R7 second done", 32'(done_flag), 1);
        check("R7 second uses old sel", 32'(result_sel), 32'h41);
        pulse_clr();
        tick(12);
        check("R7 third done", 32'(done_flag), 1);
        check("R7 third uses new sel", 32'(result_sel), 32'h42);
        mode = 2'd0;
        tick(13);
        check("R7 chain stops", 32'(busy), 0);
        tick(2);
        check("R7 stays idle", 32'(busy), 0);

        // R8: triggered mode
        pulse_clr();
        mode = 2'd2;
        trig_in = 1'b1;
        tick(1);
        check("R8 not busy on trigger edge", 32'(busy), 0);
        tick(1);
        check("R8 trigger starts", 32'(busy), 1);
        tick(3);
        trig_in = 1'b0;
        tick(2);
        trig_in = 1'b1;
        tick(2);
        tick(6);
        check("R8 done", 32'(done_flag), 1);
        check("R8 busy falls", 32'(busy), 0);
        tick(3);
        check("R8 trigger while busy not queued", 32'(busy), 0);
        mode = 2'd0;
        trig_in = 1'b0;
        tick(1);
        trig_in = 1'b1;
        tick(3);
        check("R8 trigger ignored in single mode", 32'(busy), 0);
        trig_in = 1'b0;

        // R11: abort by disable
        pulse_clr();
        pulse_start();
        tick(1);
        check("R11 running", 32'(busy), 1);
        tick(5);
        en = 1'b0;
        tick(1);
        check("R11 aborted", 32'(busy), 0);
        write_sel(7'h2C);
        tick(1);
        check("R11 shadow tracks", 32'({mux_ref, mux_chan}), 32'h2C);
        pulse_start();
        tick(2);
        check("R4 start disabled ignored", 32'(busy), 0);
        tick(20);
        check("R11 no flag", 32'(done_flag), 0);
        en = 1'b1;
        tick(1);

        // R10: set wins over clear
        pulse_start();
        flag_clr = 1'b1;
        tick(14);
        check("R10 set wins", 32'(done_flag), 1);
        tick(1);
        check("R10 clear", 32'(done_flag), 0);
        flag_clr = 1'b0;

        // R1: reset mid-conversion
        pulse_start();
        tick(3);
        rst = 1'b1;
        tick(1);
        check("R1 reset busy", 32'(busy), 0);
        check("R1 reset sel_reg", 32'(sel_reg), 0);
        rst = 1'b0;
        tick(2);

        summary();
    end

endmodule